// File: doc/BRIEF.md
# Transmit Symbol Stream and Modulation Controller

This block produces the symbol stream for a radio transmitter and turns it into modulation control. The symbol source is picked from three places: a configuration bit, a transparent input pin, or a framed path. The framed path assembles a telegram from two read-ahead FIFOs, one symbol per symbol-rate tick. It sends the synchronisation bytes from a support FIFO without coding. It then sends the payload bytes from a data FIFO, optionally Manchester coded. An optional 8-bit checksum and an optional short raw stop pattern can follow the payload.

Each symbol drives the modulation outputs. In amplitude keying the symbol gates the power-amplifier enable directly. In frequency keying the amplifier stays on and the symbol picks one of two frequency words. A one-cycle completion pulse marks the end of a frame. A sticky underrun flag marks a frame that was cut short because a FIFO ran dry.

Top module: `txsym_modctl`

## Requirements
- R1: `cfg_src` selects the symbol source. Code 0 means no source: `tx_sym`=0, `pa_en`=0 and `freq_word`=`cfg_freq0`. Code 1 passes `cfg_reg_bit`, code 2 passes `tx_pin` (both without any register delay), and code 3 selects the framed path.
- R2: With `cfg_fsk`=0, while a symbol is active, `pa_en` equals the symbol and `freq_word` is always `cfg_freq0`.
- R3: With `cfg_fsk`=1, while a symbol is active, `pa_en` is 1 and `freq_word` is `cfg_freq1` for symbol 1 and `cfg_freq0` for symbol 0.
- R4: A `start` pulse with `cfg_src`=3 sets `busy`. On each later `sym_tick`, the next symbol appears in the following cycle. Order: `cfg_pre_bytes` bytes from the support FIFO, uncoded and MSB first; then `cfg_pay_bytes` (at least 1) bytes from the data FIFO, MSB first. A FIFO is popped only on a tick.
- R5: With `cfg_manch`=1, each payload and checksum bit takes two symbols: bit 1 gives 1 then 0, and bit 0 gives 0 then 1. With `cfg_manch`=0, each bit takes one symbol.
- R6: With `cfg_crc_en`=1, a checksum byte follows the payload. It is a CRC-8 with polynomial 0x07 and initial value 0x00, fed MSB first with the payload bits only. It is sent MSB first with the payload's coding.
- R7: If `cfg_stop_len` is 2 to 6, that many raw symbols close the frame, taken from `cfg_stop_pat` bit `cfg_stop_len`-1 down to bit 0. If `cfg_stop_len` is 0, no stop symbols are sent.
- R8: On the tick after the last symbol, `done` pulses for exactly one cycle, `pa_en` falls to 0 and `busy` clears.
- R9: If a FIFO is empty on the tick that needs its next byte, `underrun` is set and held until the next accepted start. On that same tick `pa_en` falls to 0 and `busy` clears, and no `done` follows.
- R10: `start` is ignored while `busy` is 1, and also when `cfg_src` is not 3. The running frame continues unchanged, and `busy` stays 0 when idle.
- R11: After reset, `pa_en`, `busy`, `done`, `underrun` and `tx_sym` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_tick | input | 1 | One-cycle symbol-rate strobe |
| start | input | 1 | Begin a framed transmission |
| cfg_src | input | 2 | Source select: 0 none, 1 register bit, 2 pin, 3 framed |
| cfg_reg_bit | input | 1 | Symbol value for source 1 |
| tx_pin | input | 1 | Transparent symbol input for source 2 |
| cfg_fsk | input | 1 | 0 amplitude keying, 1 frequency keying |
| cfg_manch | input | 1 | Manchester coding of payload and checksum |
| cfg_crc_en | input | 1 | Append checksum byte |
| cfg_pre_bytes | input | PRE_CNT_W | Support FIFO bytes per frame |
| cfg_pay_bytes | input | PAY_CNT_W | Payload bytes per frame |
| cfg_stop_len | input | $clog2(STOP_MAX+1) | Stop symbol count (0 or 2..6) |
| cfg_stop_pat | input | STOP_MAX | Stop symbol pattern |
| cfg_freq0 | input | FREQ_W | Frequency word for symbol 0 |
| cfg_freq1 | input | FREQ_W | Frequency word for symbol 1 |
| sup_empty | input | 1 | Support FIFO empty |
| sup_data | input | 8 | Support FIFO head byte (read-ahead) |
| sup_rd | output | 1 | Support FIFO pop |
| dat_empty | input | 1 | Data FIFO empty |
| dat_data | input | 8 | Data FIFO head byte (read-ahead) |
| dat_rd | output | 1 | Data FIFO pop |
| tx_sym | output | 1 | Current symbol |
| pa_en | output | 1 | Power-amplifier enable |
| freq_word | output | FREQ_W | Selected frequency word |
| busy | output | 1 | Framed transmission in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
The assertions assume the following about the inputs:
- All configuration inputs stay constant from an accepted start until `done` or `underrun`.
- `sym_tick` is a single-cycle strobe that never coincides with the start pulse.
- The stop length is 0 or 2 to 6, and the payload count is at least one.

The stimulus sets the configuration only between frames, separates ticks by at least one idle cycle, and draws stop lengths and counts only from these legal sets. Random frame shapes and random bytes from a fixed seed are mixed with directed cases: a maximal stop pattern, a mid-frame start, and a data FIFO filled short of the payload count.

// File: rtl/txsym_pkg.sv
package txsym_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

   typedef enum logic [1:0] {
      SRC_OFF = 2'd0,
      SRC_REG = 2'd1,
      SRC_PIN = 2'd2,
      SRC_BUF = 2'd3
   } src_t;

   typedef enum logic [2:0] {
      SEG_PRE  = 3'd0,
      SEG_PAY  = 3'd1,
      SEG_CRC  = 3'd2,
      SEG_STOP = 3'd3,
      SEG_END  = 3'd4
   } seg_t;
endpackage

// File: rtl/txsym_crc8.sv
module txsym_crc8
   import txsym_pkg::*;
#(
   parameter logic [BYTE_W-1:0] POLY = CRC_POLY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic              bit_in,
   output logic [BYTE_W-1:0] crc
);
   logic [BYTE_W-1:0] crc_q, crc_nx;
   logic              fb;

   assign fb = crc_q[BYTE_W-1] ^ bit_in;

   // one LFSR stage per bit; taps follow the polynomial parameter
   for (genvar i = 0; i < BYTE_W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign crc_nx[i] = POLY[i] & fb;
      end else begin : g_mid
         assign crc_nx[i] = crc_q[i-1] ^ (POLY[i] & fb);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clr)   crc_q <= '0;
      else if (step)  crc_q <= crc_nx;
   end

   assign crc = crc_q;
endmodule

// File: rtl/txsym_framer.sv
module txsym_framer
   import txsym_pkg::*;
#(
   parameter int PRE_CNT_W = 4,
   parameter int PAY_CNT_W = 7,
   parameter int STOP_MAX  = 6,
   localparam int SL_W  = $clog2(STOP_MAX + 1),
   localparam int CNT_W = (PRE_CNT_W > PAY_CNT_W) ? PRE_CNT_W : PAY_CNT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sym_tick,
   input  logic                 go,
   input  logic                 cfg_manch,
   input  logic                 cfg_crc_en,
   input  logic [PRE_CNT_W-1:0] cfg_pre_bytes,
   input  logic [PAY_CNT_W-1:0] cfg_pay_bytes,
   input  logic [SL_W-1:0]      cfg_stop_len,
   input  logic [STOP_MAX-1:0]  cfg_stop_pat,
   input  logic                 sup_empty,
   input  logic [BYTE_W-1:0]    sup_data,
   output logic                 sup_rd,
   input  logic                 dat_empty,
   input  logic [BYTE_W-1:0]    dat_data,
   output logic                 dat_rd,
   output logic                 busy,
   output logic                 act,
   output logic                 sym,
   output logic                 done,
   output logic                 underrun
);
   seg_t              seg_q, nxt_seg;
   logic              run_q, act_q, sym_q, done_q, unr_q;
   logic [BYTE_W-1:0] byt_q, new_byte, cur;
   logic [2:0]        bi_q;
   logic [CNT_W-1:0]  left_q;
   logic [SL_W-1:0]   stop_q;
   logic              half_q, hold_q, fin_q;
   logic              bit_seg, coded, second, need, empty_hit, take, seg_done, emit;
   logic              crc_step;
   logic [BYTE_W-1:0] crc_val;

   assign bit_seg   = (seg_q == SEG_PRE) || (seg_q == SEG_PAY) || (seg_q == SEG_CRC);
   assign coded     = cfg_manch && ((seg_q == SEG_PAY) || (seg_q == SEG_CRC));
   assign second    = coded && half_q;
   assign need      = bit_seg && !second && (bi_q == 3'd0);
   assign empty_hit = sym_tick && run_q && need &&
                      (((seg_q == SEG_PRE) && sup_empty) || ((seg_q == SEG_PAY) && dat_empty));
   assign take      = sym_tick && run_q && bit_seg && !second && !empty_hit;

   always_comb begin
      case (seg_q)
         SEG_PRE: new_byte = sup_data;
         SEG_PAY: new_byte = dat_data;
         default: new_byte = crc_val;
      endcase
   end
   assign cur = need ? new_byte : byt_q;

   assign sup_rd   = take && need && (seg_q == SEG_PRE);
   assign dat_rd   = take && need && (seg_q == SEG_PAY);
   assign crc_step = take && (seg_q == SEG_PAY);

   assign seg_done = (take && !coded && (bi_q == 3'd7) && (left_q == CNT_W'(1))) ||
                     (sym_tick && run_q && second && fin_q);

   always_comb begin
      case (seg_q)
         SEG_PRE: nxt_seg = SEG_PAY;
         SEG_PAY: nxt_seg = cfg_crc_en ? SEG_CRC :
                            ((cfg_stop_len != '0) ? SEG_STOP : SEG_END);
         default: nxt_seg = (cfg_stop_len != '0) ? SEG_STOP : SEG_END;
      endcase
   end

   always_comb begin
      if (seg_q == SEG_STOP) emit = cfg_stop_pat[stop_q];
      else if (second)       emit = ~hold_q;
      else                   emit = cur[BYTE_W-1];
   end

   txsym_crc8 #(.POLY(CRC_POLY)) i_crc (
      .clk(clk), .rst_n(rst_n), .clr(go), .step(crc_step),
      .bit_in(cur[BYTE_W-1]), .crc(crc_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= SEG_PRE; run_q <= 1'b0; act_q <= 1'b0; sym_q <= 1'b0;
         done_q <= 1'b0; unr_q <= 1'b0; byt_q <= '0; bi_q <= '0;
         left_q <= '0; stop_q <= '0; half_q <= 1'b0; hold_q <= 1'b0; fin_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            run_q  <= 1'b1; act_q <= 1'b0; sym_q <= 1'b0; unr_q <= 1'b0;
            bi_q   <= '0;   half_q <= 1'b0; fin_q <= 1'b0;
            if (cfg_pre_bytes != '0) begin
               seg_q <= SEG_PRE; left_q <= CNT_W'(cfg_pre_bytes);
            end else begin
               seg_q <= SEG_PAY; left_q <= CNT_W'(cfg_pay_bytes);
            end
         end else if (sym_tick && run_q) begin
            if (empty_hit) begin
               run_q <= 1'b0; act_q <= 1'b0; sym_q <= 1'b0; unr_q <= 1'b1;
            end else if (seg_q == SEG_END) begin
               run_q <= 1'b0; act_q <= 1'b0; sym_q <= 1'b0; done_q <= 1'b1;
            end else begin
               act_q <= 1'b1;
               sym_q <= emit;
               if (seg_q == SEG_STOP) begin
                  if (stop_q == '0) seg_q  <= SEG_END;
                  else              stop_q <= stop_q - 1'b1;
               end else begin
                  if (take) begin
                     byt_q <= {cur[BYTE_W-2:0], 1'b0};
                     bi_q  <= bi_q + 3'd1;
                     if (bi_q == 3'd7) left_q <= left_q - 1'b1;
                     if (coded) begin
                        half_q <= 1'b1;
                        hold_q <= cur[BYTE_W-1];
                        if ((bi_q == 3'd7) && (left_q == CNT_W'(1))) fin_q <= 1'b1;
                     end
                  end else begin
                     half_q <= 1'b0;
                  end
                  if (seg_done) begin
                     seg_q  <= nxt_seg;
                     fin_q  <= 1'b0;
                     left_q <= (nxt_seg == SEG_PAY) ? CNT_W'(cfg_pay_bytes) : CNT_W'(1);
                     stop_q <= cfg_stop_len - 1'b1;
                  end
               end
            end
         end
      end
   end

   assign busy     = run_q;
   assign act      = act_q;
   assign sym      = sym_q;
   assign done     = done_q;
   assign underrun = unr_q;

   // FIFO pops only happen on a symbol tick of a running frame
   assert_rd_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_rd || dat_rd) |-> (sym_tick && run_q));

   // second half of a coded bit is always the complement of the first
   assert_manch_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_tick && run_q && second && !go) |=> (sym_q != $past(sym_q)));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_unr_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unr_q) |-> (!done_q && !run_q));
endmodule

// File: rtl/txsym_map.sv
module txsym_map
   import txsym_pkg::*;
#(
   parameter int FREQ_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_src,
   input  logic              cfg_reg_bit,
   input  logic              tx_pin,
   input  logic              cfg_fsk,
   input  logic [FREQ_W-1:0] cfg_freq0,
   input  logic [FREQ_W-1:0] cfg_freq1,
   input  logic              buf_act,
   input  logic              buf_sym,
   output logic              tx_sym,
   output logic              pa_en,
   output logic [FREQ_W-1:0] freq_word
);
   src_t src;
   logic active, raw;

   assign src = src_t'(cfg_src);

   always_comb begin
      case (src)
         SRC_REG: begin active = 1'b1;    raw = cfg_reg_bit; end
         SRC_PIN: begin active = 1'b1;    raw = tx_pin;      end
         SRC_BUF: begin active = buf_act; raw = buf_sym;     end
         default: begin active = 1'b0;    raw = 1'b0;        end
      endcase
   end

   assign tx_sym    = active & raw;
   assign pa_en     = active & (cfg_fsk | raw);
   assign freq_word = (cfg_fsk & tx_sym) ? cfg_freq1 : cfg_freq0;

   assert_ask_freq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_fsk |-> (freq_word == cfg_freq0));

   assert_fsk_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fsk && (src == SRC_REG || src == SRC_PIN)) |-> pa_en);
endmodule

// File: rtl/txsym_modctl.sv
module txsym_modctl
   import txsym_pkg::*;
#(
   parameter int FREQ_W    = 24,
   parameter int PRE_CNT_W = 4,
   parameter int PAY_CNT_W = 7,
   parameter int STOP_MAX  = 6,
   localparam int SL_W = $clog2(STOP_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sym_tick,
   input  logic                 start,
   input  logic [1:0]           cfg_src,
   input  logic                 cfg_reg_bit,
   input  logic                 tx_pin,
   input  logic                 cfg_fsk,
   input  logic                 cfg_manch,
   input  logic                 cfg_crc_en,
   input  logic [PRE_CNT_W-1:0] cfg_pre_bytes,
   input  logic [PAY_CNT_W-1:0] cfg_pay_bytes,
   input  logic [SL_W-1:0]      cfg_stop_len,
   input  logic [STOP_MAX-1:0]  cfg_stop_pat,
   input  logic [FREQ_W-1:0]    cfg_freq0,
   input  logic [FREQ_W-1:0]    cfg_freq1,
   input  logic                 sup_empty,
   input  logic [7:0]           sup_data,
   output logic                 sup_rd,
   input  logic                 dat_empty,
   input  logic [7:0]           dat_data,
   output logic                 dat_rd,
   output logic                 tx_sym,
   output logic                 pa_en,
   output logic [FREQ_W-1:0]    freq_word,
   output logic                 busy,
   output logic                 done,
   output logic                 underrun
);
   if (FREQ_W < 1)                    begin : g_bad_freq $error("FREQ_W must be positive"); end
   if (STOP_MAX < 2 || STOP_MAX > 7)  begin : g_bad_stop $error("STOP_MAX must be 2..7"); end
   if (PRE_CNT_W < 1 || PAY_CNT_W < 1) begin : g_bad_cnt $error("counter widths must be positive"); end

   logic go, buf_act, buf_sym;

   assign go = start && !busy && (src_t'(cfg_src) == SRC_BUF);

   txsym_framer #(
      .PRE_CNT_W(PRE_CNT_W), .PAY_CNT_W(PAY_CNT_W), .STOP_MAX(STOP_MAX)
   ) i_framer (
      .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .go(go),
      .cfg_manch(cfg_manch), .cfg_crc_en(cfg_crc_en),
      .cfg_pre_bytes(cfg_pre_bytes), .cfg_pay_bytes(cfg_pay_bytes),
      .cfg_stop_len(cfg_stop_len), .cfg_stop_pat(cfg_stop_pat),
      .sup_empty(sup_empty), .sup_data(sup_data), .sup_rd(sup_rd),
      .dat_empty(dat_empty), .dat_data(dat_data), .dat_rd(dat_rd),
      .busy(busy), .act(buf_act), .sym(buf_sym), .done(done), .underrun(underrun)
   );

   txsym_map #(.FREQ_W(FREQ_W)) i_map (
      .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_reg_bit(cfg_reg_bit),
      .tx_pin(tx_pin), .cfg_fsk(cfg_fsk), .cfg_freq0(cfg_freq0), .cfg_freq1(cfg_freq1),
      .buf_act(buf_act), .buf_sym(buf_sym),
      .tx_sym(tx_sym), .pa_en(pa_en), .freq_word(freq_word)
   );

   // framer completion and mapper amplifier gate agree
   assert_done_pa_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && src_t'(cfg_src) == SRC_BUF) |-> !pa_en);

   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && src_t'(cfg_src) != SRC_BUF && !busy) |=> !busy);
endmodule

// File: tb/test_txsym_modctl.sv
module test_txsym_modctl;
   localparam int FW = 24;
   localparam logic [FW-1:0] F0 = 24'h1A2B3C;
   localparam logic [FW-1:0] F1 = 24'h4D5E6F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sym_tick = 1'b0, start = 1'b0;
   logic [1:0] cfg_src = 2'd0;
   logic cfg_reg_bit = 1'b0, tx_pin = 1'b0, cfg_fsk = 1'b0, cfg_manch = 1'b0, cfg_crc_en = 1'b0;
   logic [3:0] cfg_pre_bytes = '0;
   logic [6:0] cfg_pay_bytes = 7'd1;
   logic [2:0] cfg_stop_len = '0;
   logic [5:0] cfg_stop_pat = '0;
   logic sup_empty, dat_empty, sup_rd, dat_rd;
   logic [7:0] sup_data, dat_data;
   logic tx_sym, pa_en, busy, done, underrun;
   logic [FW-1:0] freq_word;

   logic [7:0] smem [0:63];
   logic [7:0] dmem [0:63];
   int swp = 0, dwp = 0;
   int srp, drp;

   int checks = 0, failures = 0;
   bit finished = 0;
   logic ex   [0:1023];
   int   extg [0:1023];
   int   ex_n;

   always #2 clk = ~clk;

   txsym_modctl i_txsym_modctl (
      .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .start(start),
      .cfg_src(cfg_src), .cfg_reg_bit(cfg_reg_bit), .tx_pin(tx_pin),
      .cfg_fsk(cfg_fsk), .cfg_manch(cfg_manch), .cfg_crc_en(cfg_crc_en),
      .cfg_pre_bytes(cfg_pre_bytes), .cfg_pay_bytes(cfg_pay_bytes),
      .cfg_stop_len(cfg_stop_len), .cfg_stop_pat(cfg_stop_pat),
      .cfg_freq0(F0), .cfg_freq1(F1),
      .sup_empty(sup_empty), .sup_data(sup_data), .sup_rd(sup_rd),
      .dat_empty(dat_empty), .dat_data(dat_data), .dat_rd(dat_rd),
      .tx_sym(tx_sym), .pa_en(pa_en), .freq_word(freq_word),
      .busy(busy), .done(done), .underrun(underrun)
   );

   assign sup_empty = (srp == swp);
   assign dat_empty = (drp == dwp);
   assign sup_data  = smem[srp[5:0]];
   assign dat_data  = dmem[drp[5:0]];

   always @(posedge clk) begin
      if (!rst_n) begin srp <= 0; drp <= 0; end
      else begin
         if (sup_rd) srp <= srp + 1;
         if (dat_rd) drp <= drp + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic b);
      logic f;
      f = c[7] ^ b;
      return f ? ((c << 1) ^ 8'h07) : (c << 1);
   endfunction

   task automatic push_bits(input logic [7:0] v, input bit code, input int tg);
      for (int b = 7; b >= 0; b--) begin
         ex[ex_n] = v[b]; extg[ex_n] = tg; ex_n++;
         if (code) begin ex[ex_n] = ~v[b]; extg[ex_n] = 5; ex_n++; end
      end
   endtask

   task automatic tick();
      @(negedge clk) sym_tick = 1'b1;
      @(negedge clk) sym_tick = 1'b0;
   endtask

   task automatic gap();
      repeat ($urandom % 3) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_frame(input int pre_n, input int pay_n, input int fill_n,
                            input bit manch, input bit crc, input int slen,
                            input logic [5:0] spat, input bit fsk, input bit poke);
      logic [7:0] c, v;
      bit short;
      c = 8'h00; ex_n = 0; short = (fill_n < pay_n);
      cfg_src = 2'd3; cfg_fsk = fsk; cfg_manch = manch; cfg_crc_en = crc;
      cfg_pre_bytes = 4'(pre_n); cfg_pay_bytes = 7'(pay_n);
      cfg_stop_len = 3'(slen); cfg_stop_pat = spat;
      for (int i = 0; i < pre_n; i++) begin
         v = 8'($urandom); smem[swp[5:0]] = v; swp++; push_bits(v, 1'b0, 4);
      end
      for (int i = 0; i < fill_n; i++) begin
         v = 8'($urandom); dmem[dwp[5:0]] = v; dwp++;
         push_bits(v, manch, manch ? 5 : 4);
         for (int b = 7; b >= 0; b--) c = crc_upd(c, v[b]);
      end
      if (!short) begin
         if (crc) push_bits(c, manch, 6);
         for (int i = slen - 1; i >= 0; i--) begin ex[ex_n] = spat[i]; extg[ex_n] = 7; ex_n++; end
      end
      pulse_start();
      chk("R4 busy after start", busy, 1);
      chk("R4 idle pa before first tick", pa_en, 0);
      for (int k = 0; k < ex_n; k++) begin
         tick();
         chk($sformatf("R%0d sym %0d", extg[k], k), tx_sym, ex[k]);
         if (fsk) begin
            chk("R3 pa on", pa_en, 1);
            chk("R3 freq", freq_word, ex[k] ? F1 : F0);
         end else begin
            chk("R2 pa follows sym", pa_en, ex[k]);
            chk("R2 freq", freq_word, F0);
         end
         if (poke && k == 2) begin
            pulse_start();  // R10: ignored while busy
            chk("R10 busy kept", busy, 1);
         end else gap();
      end
      tick();
      chk("R8/R9 pa off at end", pa_en, 0);
      chk("R8/R9 busy clear", busy, 0);
      if (short) begin
         chk("R9 underrun set", underrun, 1);
         chk("R9 no done", done, 0);
      end else begin
         chk("R8 done pulse", done, 1);
         chk("R9 no underrun", underrun, 0);
         @(negedge clk);
         chk("R8 done single cycle", done, 0);
      end
      gap();
   endtask

   initial begin
      #(4ns * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7319));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 pa", pa_en, 0); chk("R11 busy", busy, 0);
      chk("R11 done", done, 0); chk("R11 underrun", underrun, 0); chk("R11 sym", tx_sym, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 direct sources
      cfg_src = 2'd0; cfg_reg_bit = 1'b1; tx_pin = 1'b1; #1;
      chk("R1 off pa", pa_en, 0); chk("R1 off sym", tx_sym, 0); chk("R1 off freq", freq_word, F0);
      for (int i = 0; i < 12; i++) begin
         logic rb, pn, fk;
         rb = 1'($urandom); pn = 1'($urandom); fk = 1'($urandom);
         @(negedge clk);
         cfg_src = (i % 2 == 0) ? 2'd1 : 2'd2; cfg_reg_bit = rb; tx_pin = pn; cfg_fsk = fk; #1;
         chk("R1 direct sym", tx_sym, (i % 2 == 0) ? rb : pn);
         chk(fk ? "R3 direct pa" : "R2 direct pa", pa_en, fk ? 1'b1 : ((i % 2 == 0) ? rb : pn));
         chk("R3 direct freq", freq_word, (fk && ((i % 2 == 0) ? rb : pn)) ? F1 : F0);
      end
      // R10 start ignored when source is not framed
      cfg_src = 2'd1; cfg_fsk = 1'b0;
      pulse_start();
      chk("R10 no busy for direct source", busy, 0);

      // directed frames
      run_frame(1, 2, 2, 1'b0, 1'b1, 6, 6'b101101, 1'b0, 1'b0);  // R6 R7 NRZ, ASK
      run_frame(2, 1, 1, 1'b1, 1'b1, 2, 6'b000010, 1'b1, 1'b1);  // R5 coded, FSK, mid-frame start
      run_frame(0, 3, 3, 1'b1, 1'b0, 0, 6'b0, 1'b0, 1'b0);       // no preamble, no stop
      run_frame(1, 3, 1, 1'b0, 1'b1, 4, 6'b001011, 1'b1, 1'b0);  // R9 underrun
      chk("R9 underrun held", underrun, 1);
      run_frame(0, 2, 2, 1'b0, 1'b0, 3, 6'b000101, 1'b0, 1'b0);  // start clears underrun
      // random frames
      for (int f = 0; f < 10; f++) begin
         int sl, pr, py;
         sl = $urandom % 6; sl = (sl == 1) ? 0 : sl + ((sl == 0) ? 0 : 1);
         pr = $urandom % 3; py = 1 + ($urandom % 4);
         run_frame(pr, py, py, 1'($urandom), 1'($urandom), sl, 6'($urandom), 1'($urandom), 1'b0);
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule